// File: doc/BRIEF.md
# Multichannel DMA Control Register Bank

This block is the processor-facing register file of a sixteen-channel DMA engine. Software programs each channel's transfer parameters (a word address, a line length, a line count, a line pitch and a small control word) over a simple 32-bit read/write bus. It launches a channel by writing that channel's address register last. It can abort channels through a stop register. It manages per-channel interrupt status, interrupt enables and a two-bit-per-channel loop control. Enables and loop bits each have a second, write-one-to-clear alias, so software can clear bits without a read-modify-write.

On the engine side the bank presents every channel's stored parameters as flat vectors. It also issues one-cycle start and stop pulses, drives a loop-enable level per channel, and takes per-channel event pulses (transfer done or half buffer reached). Event pulses set sticky status bits. A single interrupt line is raised whenever any status bit is set and also enabled. Clearing a looping channel's loop bits pauses it, and setting them again resumes it.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register, every readback, `rdata`, `irq`, `ch_start`, `ch_stop` and `ch_loop` is zero.
- R2: Channel n owns four words at byte offset n*0x10: word address at +0x0, line length at +0x4, line count at +0x8, control at +0xC. The stored values appear on `ch_waddr`, `ch_xlen` and `ch_ylen` in slice n*32. Control keeps bits [5:0] only and reads back zero above them. Control bit 4 drives `ch_burst4[n]` (1 = 4-word bursts). Control bit 5 drives `ch_dir[n]` (1 = memory to device).
- R3: The line pitch of channel n is read/write at 0x100 + n*4 and appears on `ch_width` slice n*32.
- R4: A write to the word address register of channel n raises `ch_start[n]` for exactly one cycle, in the cycle after the write. Writes to any other register never raise `ch_start`.
- R5: Writing a value with bit n set to 0x140 raises `ch_stop[n]` for exactly one cycle after the write. A read of 0x140 returns zero.
- R6: Status at 0x144 has bit n set by `ch_evt[n]`, and the bit holds until it is cleared. Writing 1 to a status bit clears only that bit. When an event and a clear hit the same bit in one cycle, the bit stays set.
- R7: Enable at 0x148 is read/write (bit n = channel n). Writing 1 to a bit at 0x14C clears that enable bit, writing 0 leaves it unchanged, and a read of 0x14C returns zero.
- R8: `irq` is high exactly when some channel has both its status bit and its enable bit set. It rises in the cycle after an event on an enabled channel.
- R9: Loop control at 0x150 is read/write with bit n and bit n+16 for channel n, and `ch_loop[n]` is high only when both are set. Writing 1s to 0x15C clears the matching bits (pause). Setting them again at 0x150 resumes the channel. A read of 0x15C returns zero.
- R10: Reads of unmapped word offsets return zero, and writes to them change no register.
- R11: Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (12) | Byte offset, word aligned |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Registered read data |
| ch_waddr | output | NCH*DW | Per-channel word address |
| ch_xlen | output | NCH*DW | Per-channel line length |
| ch_ylen | output | NCH*DW | Per-channel line count |
| ch_width | output | NCH*DW | Per-channel line pitch |
| ch_burst4 | output | NCH | Per-channel 4-word burst mode |
| ch_dir | output | NCH | Per-channel direction, 1 = memory to device |
| ch_start | output | NCH | One-cycle launch pulses |
| ch_stop | output | NCH | One-cycle abort pulses |
| ch_loop | output | NCH | Per-channel loop enable |
| ch_evt | input | NCH | Per-channel event pulses |
| irq | output | 1 | Combined interrupt |

## Verification
A vector table writes and reads back every class of register: the first and last channels' parameter words, an over-wide control value whose upper bits must read back as zero, both ends of the pitch window, loop and enable patterns, the write-only stop and clear aliases, and an unmapped hole. This separates decode errors in the channel stride, the pitch window and the fixed offsets. Directed sequences then set and clear a status bit with its enable on and off, and collide an event with a clear on the same bit. They also pause and resume a loop through the alias, set only one of a channel's two loop bits, and compare address writes with other parameter writes to check that only address writes produce start pulses.

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter int NCH = 16,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NCH*DW-1:0] ch_waddr,
  output logic [NCH*DW-1:0] ch_xlen,
  output logic [NCH*DW-1:0] ch_ylen,
  output logic [NCH*DW-1:0] ch_width,
  output logic [NCH-1:0]    ch_burst4,
  output logic [NCH-1:0]    ch_dir,
  output logic [NCH-1:0]    ch_start,
  output logic [NCH-1:0]    ch_stop,
  output logic [NCH-1:0]    ch_loop,
  input  logic [NCH-1:0]    ch_evt,
  output logic              irq
);
  localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CTW = 6;
  localparam int HIB = 16;
  localparam logic [AW-1:0] CH_END  = AW'(NCH * 16);
  localparam logic [AW-1:0] WID_A   = AW'('h100);
  localparam logic [AW-1:0] WID_END = AW'('h100 + NCH * 4);
  localparam logic [AW-1:0] STOP_A  = AW'('h140);
  localparam logic [AW-1:0] STS_A   = AW'('h144);
  localparam logic [AW-1:0] EN_A    = AW'('h148);
  localparam logic [AW-1:0] ENCLR_A = AW'('h14C);
  localparam logic [AW-1:0] LOOP_A  = AW'('h150);
  localparam logic [AW-1:0] LCLR_A  = AW'('h15C);

  logic [DW-1:0]  addr_r [NCH];
  logic [DW-1:0]  xlen_r [NCH];
  logic [DW-1:0]  ylen_r [NCH];
  logic [DW-1:0]  wid_r  [NCH];
  logic [CTW-1:0] ctl_r  [NCH];
  logic [NCH-1:0] sts_r, en_r, lp_lo, lp_hi, sts_clr;
  logic [DW-1:0]  rd_mux;
  logic           in_ch, in_wid;
  logic [CHB-1:0] cs, ws;

  assign in_ch   = addr < CH_END;
  assign in_wid  = (addr >= WID_A) && (addr < WID_END);
  assign cs      = addr[CHB+3:4];
  assign ws      = addr[CHB+1:2];
  assign sts_clr = (wr_en && addr == STS_A) ? wdata[NCH-1:0] : '0;
  assign ch_loop = lp_lo & lp_hi;
  assign irq     = |(sts_r & en_r);

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign ch_waddr[i*DW +: DW] = addr_r[i];
    assign ch_xlen[i*DW +: DW]  = xlen_r[i];
    assign ch_ylen[i*DW +: DW]  = ylen_r[i];
    assign ch_width[i*DW +: DW] = wid_r[i];
    assign ch_burst4[i]         = ctl_r[i][4];
    assign ch_dir[i]            = ctl_r[i][5];
  end

  always_comb begin
    rd_mux = '0;
    if (in_ch) begin
      case (addr[3:2])
        2'd0: rd_mux = addr_r[cs];
        2'd1: rd_mux = xlen_r[cs];
        2'd2: rd_mux = ylen_r[cs];
        default: rd_mux[CTW-1:0] = ctl_r[cs];
      endcase
    end else if (in_wid) begin
      rd_mux = wid_r[ws];
    end else begin
      case (addr)
        STS_A:  rd_mux[NCH-1:0] = sts_r;
        EN_A:   rd_mux[NCH-1:0] = en_r;
        LOOP_A: begin
          rd_mux[NCH-1:0]     = lp_lo;
          rd_mux[HIB +: NCH]  = lp_hi;
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        addr_r[i] <= '0;
        xlen_r[i] <= '0;
        ylen_r[i] <= '0;
        wid_r[i]  <= '0;
        ctl_r[i]  <= '0;
      end
      sts_r    <= '0;
      en_r     <= '0;
      lp_lo    <= '0;
      lp_hi    <= '0;
      ch_start <= '0;
      ch_stop  <= '0;
      rdata    <= '0;
    end else begin
      ch_start <= '0;
      ch_stop  <= '0;
      if (wr_en) begin
        if (in_ch) begin
          case (addr[3:2])
            2'd0: begin
              addr_r[cs]   <= wdata;
              ch_start[cs] <= 1'b1;
            end
            2'd1: xlen_r[cs] <= wdata;
            2'd2: ylen_r[cs] <= wdata;
            default: ctl_r[cs] <= wdata[CTW-1:0];
          endcase
        end else if (in_wid) begin
          wid_r[ws] <= wdata;
        end else begin
          case (addr)
            STOP_A:  ch_stop <= wdata[NCH-1:0];
            EN_A:    en_r    <= wdata[NCH-1:0];
            ENCLR_A: en_r    <= en_r & ~wdata[NCH-1:0];
            LOOP_A: begin
              lp_lo <= wdata[NCH-1:0];
              lp_hi <= wdata[HIB +: NCH];
            end
            LCLR_A: begin
              lp_lo <= lp_lo & ~wdata[NCH-1:0];
              lp_hi <= lp_hi & ~wdata[HIB +: NCH];
            end
            default: ;
          endcase
        end
      end
      sts_r <= (sts_r & ~sts_clr) | ch_evt;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R6
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_evt != '0) |=> ((sts_r & $past(ch_evt)) == $past(ch_evt)));

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == STS_A) |=> ((sts_r & $past(wdata[NCH-1:0]) & ~$past(ch_evt)) == '0));

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start));

  // R4
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start != '0) |-> $past(wr_en && addr < CH_END && addr[3:2] == 2'd0));

  // R5
  stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_stop != '0) |-> $past(wr_en && addr == STOP_A));

  // R7
  enclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ENCLR_A) |=> ((en_r & $past(wdata[NCH-1:0])) == '0));

  // R9
  loop_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == LCLR_A) |=>
      ((ch_loop & ($past(wdata[NCH-1:0]) | $past(wdata[HIB +: NCH]))) == '0));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_evt & en_r) != '0 && !(wr_en && (addr == EN_A || addr == ENCLR_A))) |=> irq);
endmodule

// File: tb/dma_regbank_bench.sv
module dma_regbank_bench;
  localparam int NCH = 16;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam time TCLK = 10ns;
  localparam int NVEC = 12;
  localparam logic [75:0] VEC [NVEC] = '{
    {12'h000, 32'h12345678, 32'h12345678},
    {12'h0F4, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {12'h068, 32'h0000FFFF, 32'h0000FFFF},
    {12'h03C, 32'hFFFFFFFF, 32'h0000003F},
    {12'h13C, 32'hDEADBEEF, 32'hDEADBEEF},
    {12'h100, 32'h00000011, 32'h00000011},
    {12'h150, 32'h00050005, 32'h00050005},
    {12'h148, 32'h0000F00F, 32'h0000F00F},
    {12'h140, 32'h00000000, 32'h00000000},
    {12'h160, 32'hFFFFFFFF, 32'h00000000},
    {12'h144, 32'h00000000, 32'h00000000},
    {12'h14C, 32'h00000000, 32'h00000000}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, rv;
  logic [NCH*DW-1:0] ch_waddr, ch_xlen, ch_ylen, ch_width;
  logic [NCH-1:0] ch_burst4, ch_dir, ch_start, ch_stop, ch_loop;
  logic [NCH-1:0] ch_evt = '0;
  logic irq;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  dma_regbank #(.NCH(NCH), .AW(AW), .DW(DW)) u_dma_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_waddr(ch_waddr), .ch_xlen(ch_xlen),
    .ch_ylen(ch_ylen), .ch_width(ch_width), .ch_burst4(ch_burst4),
    .ch_dir(ch_dir), .ch_start(ch_start), .ch_stop(ch_stop),
    .ch_loop(ch_loop), .ch_evt(ch_evt), .irq(irq));

  always #(TCLK/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic evt(input logic [NCH-1:0] e);
    ch_evt = e;
    @(posedge clk); @(negedge clk);
    ch_evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, '0);
    chk("R1 irq/loop/start/stop", {15'd0, irq, ch_loop}, '0);
    chk("R1 pulses", {ch_start, ch_stop}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h150, rv); chk("R1 loop reg", rv, '0);
    rd(12'h0F4, rv); chk("R1 xlen15", rv, '0);
    rd(12'h144, rv); chk("R1 status", rv, '0);

    // R2 R3 R5 R7 R9 R10 R11 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], rv);
      chk($sformatf("R2/R3/R10 vec%0d @%h", i, VEC[i][75:64]), rv, VEC[i][31:0]);
    end
    // R11 rdata holds without rd_en
    @(negedge clk); @(negedge clk);
    chk("R11 hold", rdata, '0);
    rd(12'h068, rv);
    addr = 12'h000;
    @(negedge clk); @(negedge clk);
    chk("R11 hold after read", rdata, 32'h0000FFFF);

    // R2 outputs
    chk("R2 xlen15 out", ch_xlen[15*DW +: DW], 32'hA5A5A5A5);
    chk("R2 waddr0 out", ch_waddr[0 +: DW], 32'h12345678);
    chk("R2 ylen6 out", ch_ylen[6*DW +: DW], 32'h0000FFFF);
    chk("R2 ctrl3 burst/dir", {30'd0, ch_burst4[3], ch_dir[3]}, 32'd3);
    wr(12'h03C, 32'h00000010);
    chk("R2 ctrl3 burst only", {30'd0, ch_burst4[3], ch_dir[3]}, 32'd2);
    chk("R3 width15 out", ch_width[15*DW +: DW], 32'hDEADBEEF);
    chk("R9 loop out", {16'd0, ch_loop}, 32'h0005);

    // R4 start pulses
    wr(12'h050, 32'h00000400);
    chk("R4 start ch5", {16'd0, ch_start}, 32'h0020);
    @(negedge clk);
    chk("R4 start one cycle", {16'd0, ch_start}, '0);
    wr(12'h054, 32'h00000010);
    chk("R4 no start on xlen", {16'd0, ch_start}, '0);
    wr(12'h05C, 32'h00000005);
    chk("R4 no start on ctrl", {16'd0, ch_start}, '0);

    // R5 stop pulses
    wr(12'h140, 32'h00008001);
    chk("R5 stop ch0 ch15", {16'd0, ch_stop}, 32'h8001);
    @(negedge clk);
    chk("R5 stop one cycle", {16'd0, ch_stop}, '0);
    rd(12'h140, rv); chk("R5 stop reads zero", rv, '0);

    // R6 R8 status and interrupt
    chk("R8 irq idle", {31'd0, irq}, '0);
    evt(16'h0002);
    chk("R8 irq enabled ch1", {31'd0, irq}, 32'd1);
    @(negedge clk);
    rd(12'h144, rv); chk("R6 status held", rv, 32'h0002);
    wr(12'h144, 32'h00000002);
    chk("R8 irq after clear", {31'd0, irq}, '0);
    rd(12'h144, rv); chk("R6 status cleared", rv, '0);
    evt(16'h0010);
    chk("R8 irq masked ch4", {31'd0, irq}, '0);
    wr(12'h148, 32'h0000F01F);
    chk("R8 irq on enable", {31'd0, irq}, 32'd1);
    wr(12'h14C, 32'h00000010);
    chk("R7 irq after enable clear", {31'd0, irq}, '0);
    rd(12'h148, rv); chk("R7 enable after alias", rv, 32'h0000F00F);
    rd(12'h14C, rv); chk("R7 alias reads zero", rv, '0);
    wr(12'h144, 32'h00000010);
    evt(16'h0005);
    wr(12'h144, 32'h00000001);
    rd(12'h144, rv); chk("R6 clear only bit0", rv, 32'h0004);
    ch_evt = 16'h0004;
    wr(12'h144, 32'h00000004);
    ch_evt = '0;
    rd(12'h144, rv); chk("R6 event wins over clear", rv, 32'h0004);

    // R9 loop pause / resume
    wr(12'h15C, 32'h00010000);
    chk("R9 pause ch0", {16'd0, ch_loop}, 32'h0004);
    rd(12'h150, rv); chk("R9 loop reg after pause", rv, 32'h00040005);
    rd(12'h15C, rv); chk("R9 clear alias reads zero", rv, '0);
    wr(12'h150, 32'h00050005);
    chk("R9 resume ch0", {16'd0, ch_loop}, 32'h0005);
    wr(12'h150, 32'h00000008);
    chk("R9 single bit no loop", {16'd0, ch_loop}, '0);

    // R10 unmapped writes leave state
    wr(12'h1FC, 32'hFFFFFFFF);
    rd(12'h150, rv); chk("R10 loop untouched", rv, 32'h00000008);
    rd(12'h148, rv); chk("R10 enable untouched", rv, 32'h0000F00F);
    chk("R10 no pulses", {ch_start, ch_stop}, '0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule